// File: doc/BRIEF.md
# Threshold-Based Defective Pixel Corrector

This block cleans isolated bad pixels out of a raster pixel stream. For every pixel it forms the rounded mean of the 24 pixels around it in a 5x5 window, leaving the pixel itself out. It then measures how far that mean is from the pixel. If the gap is larger than one eighth of the pixel's own value, the pixel is taken to be defective and the mean is sent out in its place. Otherwise the pixel leaves the block unchanged. Four internal line stores keep the earlier rows, so the source only has to deliver a plain raster with a start-of-frame flag.

The frame size is fixed by parameters. At the image borders, missing neighbours are filled by repeating the nearest edge pixel, so the output frame is exactly as large as the input frame. The window centre trails the input by two lines and two pixels. When the last input pixel of a frame has been taken, the block generates that many drain steps by itself, one per cycle, to push out the remaining rows.

Top module: `spot_corrector`

## Requirements
- R1: The mean of a pixel's window is floor((S + 12) / 24), where S is the sum of the 24 window pixels other than the centre.
- R2: The output is the mean when |mean − pixel| > (pixel >> 3). Otherwise the output is the pixel. A gap exactly equal to pixel >> 3 keeps the pixel.
- R3: A window position that falls outside the frame takes the value of the nearest pixel inside the frame, clamping the row and the column separately.
- R4: Each frame produces exactly IMG_W*IMG_H output pixels in raster order. outSof is high only with the first pixel, and outEol is high exactly with every pixel in column IMG_W-1.
- R5: Let LAG = 2*IMG_W+2. The output for raster pixel k appears 3 clock edges after the beat that carries pixel k+LAG. For k+LAG ≥ IMG_W*IMG_H, that beat is the drain step taken on edge (k+LAG−IMG_W*IMG_H+1) after the edge of the last input pixel.
- R6: While no frame is open, a beat with inValid high and inSof low is ignored and produces no output.
- R7: During reset and until the first beat, outValid, outSof and outEol are low.
- R8: Input beats that arrive during the LAG drain cycles after the last pixel of a frame are ignored, including any inSof among them.
- R9: Idle cycles between input beats of a frame leave every output value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present this cycle |
| inSof | input | 1 | Marks the first pixel of a frame |
| inPix | input | PIX_W | Input pixel value |
| outValid | output | 1 | Output pixel present this cycle |
| outSof | output | 1 | First output pixel of a frame |
| outEol | output | 1 | Last output pixel of a line |
| outPix | output | PIX_W | Corrected pixel value |

## Verification
Every output pixel is tied to a specific input beat. The bench records the clock edge on which each input pixel is accepted and expects the output for raster pixel k on the edge three later than the beat of pixel k+LAG. For the last LAG pixels of a frame, it counts the drain steps that follow the final input edge instead. The bench samples the outputs on falling edges, and it compares each pixel's value, flags and arrival edge against a model computed from the frame image. It checks a frame only after the drain has finished and six further cycles have passed. Frames that contain idle gaps and frames with junk beats during the drain are held to the same edge arithmetic.

// File: rtl/spot_corrector_pkg.sv
package spot_corrector_pkg;
  localparam int COORD_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH
  } spot_state_e;

  typedef struct packed {
    logic               beat;
    logic               usePix;
    logic               cValid;
    logic               cSof;
    logic               cEol;
    logic [COORD_W-1:0] inRow;
    logic [COORD_W-1:0] inCol;
    logic [COORD_W-1:0] cCol;
  } spot_strobe_t;
endpackage

// File: rtl/spot_ctrl.sv
module spot_ctrl
  import spot_corrector_pkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inSof,
  output spot_strobe_t strb
);
  localparam int PIX_CNT = IMG_W * IMG_H;
  localparam int LAG     = 2 * IMG_W + 2;
  localparam int TOTAL   = PIX_CNT + LAG;
  localparam int IDX_W   = $clog2(TOTAL + 1);

  spot_state_e        state;
  logic [IDX_W-1:0]   beatIdx, curIdx;
  logic [COORD_W-1:0] colCnt, rowCnt, cColCnt;
  logic [COORD_W-1:0] curCol, curRow, curCCol;
  logic               beat, centreOn;

  always_comb begin
    curIdx   = (state == ST_IDLE) ? '0 : beatIdx;
    curCol   = (state == ST_IDLE) ? '0 : colCnt;
    curRow   = (state == ST_IDLE) ? '0 : rowCnt;
    curCCol  = (state == ST_IDLE) ? '0 : cColCnt;
    beat     = (state == ST_FLUSH) ? 1'b1 : (inValid && (state == ST_RUN || inSof));
    centreOn = beat && (curIdx >= IDX_W'(LAG));
    strb.beat   = beat;
    strb.usePix = (state != ST_FLUSH);
    strb.cValid = centreOn;
    strb.cSof   = beat && (curIdx == IDX_W'(LAG));
    strb.cEol   = centreOn && (curCCol == COORD_W'(IMG_W - 1));
    strb.inRow  = curRow;
    strb.inCol  = curCol;
    strb.cCol   = curCCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatIdx <= '0;
      colCnt  <= '0;
      rowCnt  <= '0;
      cColCnt <= '0;
    end else if (beat) begin
      beatIdx <= curIdx + 1'b1;
      if (curCol == COORD_W'(IMG_W - 1)) begin
        colCnt <= '0;
        rowCnt <= curRow + 1'b1;
      end else begin
        colCnt <= curCol + 1'b1;
        rowCnt <= curRow;
      end
      if (centreOn)
        cColCnt <= (curCCol == COORD_W'(IMG_W - 1)) ? '0 : curCCol + 1'b1;
      else
        cColCnt <= curCCol;
      if (curIdx == IDX_W'(TOTAL - 1))
        state <= ST_IDLE;
      else if (curIdx == IDX_W'(PIX_CNT - 1))
        state <= ST_FLUSH;
      else if (state == ST_IDLE)
        state <= ST_RUN;
    end
  end

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (beatIdx < IDX_W'(TOTAL)));

  // R8
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |=> (state != ST_RUN));
endmodule

// File: rtl/spot_datapath.sv
module spot_datapath
  import spot_corrector_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  spot_strobe_t     strb,
  input  logic [PIX_W-1:0] inPix,
  output logic             outValid,
  output logic             outSof,
  output logic             outEol,
  output logic [PIX_W-1:0] outPix
);
  localparam int SUM_W  = PIX_W + 5;
  localparam int SHIFT  = SUM_W + 5;
  localparam int REC_W  = SHIFT - 3;
  localparam int PROD_W = SUM_W + REC_W;
  localparam int CI_W   = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam logic [REC_W-1:0] RECIP = REC_W'(((64'd1 << SHIFT) + 64'd23) / 64'd24);

  logic [PIX_W-1:0] taps [5];
  logic [PIX_W-1:0] vcol [5];
  logic [PIX_W-1:0] win  [5][5];
  logic [CI_W-1:0]  colIdx;

  assign colIdx  = strb.inCol[CI_W-1:0];
  assign taps[0] = strb.usePix ? inPix : '0;

  for (genvar g = 0; g < 4; g++) begin : g_line
    logic [PIX_W-1:0] mem [IMG_W];
    assign taps[g+1] = mem[colIdx];
    always_ff @(posedge clk) begin
      if (strb.beat) mem[colIdx] <= taps[g];
    end
  end

  // vertical clamp: offset k-2 around centre row (inRow-2)
  always_comb begin
    int rr, ts;
    for (int k = 0; k < 5; k++) begin
      rr = int'(strb.inRow) + k - 4;
      if (rr < 0) rr = 0;
      if (rr > IMG_H - 1) rr = IMG_H - 1;
      ts = int'(strb.inRow) - rr;
      if (ts < 0) ts = 0;
      if (ts > 4) ts = 4;
      vcol[k] = taps[ts[2:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.beat) begin
      win[0] <= vcol;
      for (int j = 1; j < 5; j++) win[j] <= win[j-1];
    end
  end

  // stage A: centre bookkeeping at the beat
  logic               sAValid, sASof, sAEol;
  logic [COORD_W-1:0] sACol;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sAValid <= 1'b0; sASof <= 1'b0; sAEol <= 1'b0; sACol <= '0;
    end else begin
      sAValid <= strb.cValid; sASof <= strb.cSof; sAEol <= strb.cEol; sACol <= strb.cCol;
    end
  end

  // stage B: horizontal clamp and sum of 24 neighbours
  logic [2:0]       hj [5];
  logic [SUM_W-1:0] sumNext;
  always_comb begin
    int x;
    for (int m = 0; m < 5; m++) begin
      x = int'(sACol) + m - 2;
      if (x < 0) x = 0;
      if (x > IMG_W - 1) x = IMG_W - 1;
      x = 2 + int'(sACol) - x;
      if (x < 0) x = 0;
      if (x > 4) x = 4;
      hj[m] = x[2:0];
    end
    sumNext = '0;
    for (int k = 0; k < 5; k++)
      for (int m = 0; m < 5; m++)
        if (!(k == 2 && m == 2)) sumNext = sumNext + SUM_W'(win[hj[m]][k]);
  end

  logic             sBValid, sBSof, sBEol;
  logic [SUM_W-1:0] sBSum;
  logic [PIX_W-1:0] sBPix;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sBValid <= 1'b0; sBSof <= 1'b0; sBEol <= 1'b0; sBSum <= '0; sBPix <= '0;
    end else begin
      sBValid <= sAValid; sBSof <= sASof; sBEol <= sAEol;
      sBSum   <= sumNext;
      sBPix   <= win[2][2];
    end
  end

  // stage C: rounded divide by 24 through reciprocal multiply
  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'(sBSum + SUM_W'(12)) * PROD_W'(RECIP);

  logic             sCValid, sCSof, sCEol;
  logic [PIX_W-1:0] sCAvg, sCPix;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sCValid <= 1'b0; sCSof <= 1'b0; sCEol <= 1'b0; sCAvg <= '0; sCPix <= '0;
    end else begin
      sCValid <= sBValid; sCSof <= sBSof; sCEol <= sBEol;
      sCAvg   <= prod[SHIFT +: PIX_W];
      sCPix   <= sBPix;
    end
  end

  // stage D: tolerance test and select
  logic [PIX_W-1:0] gap, tol;
  always_comb begin
    gap = (sCAvg >= sCPix) ? (sCAvg - sCPix) : (sCPix - sCAvg);
    tol = sCPix >> 3;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outSof <= 1'b0; outEol <= 1'b0; outPix <= '0;
    end else begin
      outValid <= sCValid; outSof <= sCSof; outEol <= sCEol;
      outPix   <= (gap > tol) ? sCAvg : sCPix;
    end
  end

  logic [SUM_W+1:0] avgX24;
  assign avgX24 = (SUM_W+2)'(sCAvg) * (SUM_W+2)'(24);

  // R1
  div_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    sBValid |=> (((SUM_W+2)'($past(sBSum)) + (SUM_W+2)'(12) >= avgX24) &&
                 ((SUM_W+2)'($past(sBSum)) + (SUM_W+2)'(12) <  avgX24 + (SUM_W+2)'(24))));

  // R2
  sel_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    sCValid |=> (outPix == $past(sCPix) || outPix == $past(sCAvg)));

  // R2
  keep_in_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sCValid && gap <= tol) |=> (outPix == $past(sCPix)));
endmodule

// File: rtl/spot_corrector.sv
module spot_corrector
  import spot_corrector_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic [PIX_W-1:0] inPix,
  output logic             outValid,
  output logic             outSof,
  output logic             outEol,
  output logic [PIX_W-1:0] outPix
);
  spot_strobe_t strb;

  spot_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .strb(strb)
  );

  spot_datapath #(.PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inPix(inPix),
    .outValid(outValid), .outSof(outSof), .outEol(outEol), .outPix(outPix)
  );
endmodule

// File: tb/spot_corrector_tb.sv
module spot_corrector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8, TH = 6, NPIX = TW * TH, LAG = 2 * TW + 2, PW = 24;
  localparam int FOCUS = 2 * TW + 3;
  localparam int NVEC = 11;
  // {centre value, uniform neighbour value, expected output}
  localparam logic [71:0] VEC [NVEC] = '{
    {24'd800,    24'd900,    24'd800},
    {24'd800,    24'd901,    24'd901},
    {24'd800,    24'd700,    24'd800},
    {24'd800,    24'd699,    24'd699},
    {24'd0,      24'd1,      24'd1},
    {24'd0,      24'd0,      24'd0},
    {24'd7,      24'd8,      24'd8},
    {24'hFFFFFF, 24'h000000, 24'h000000},
    {24'h000000, 24'hFFFFFF, 24'hFFFFFF},
    {24'hFFFFFF, 24'hE00000, 24'hFFFFFF},
    {24'hFFFFFF, 24'hDFFFFF, 24'hDFFFFF}
  };

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inSof = 1'b0;
  logic [PW-1:0] inPix = '0;
  logic outValid, outSof, outEol;
  logic [PW-1:0] outPix;

  always #(CLK_PERIOD/2) clk = ~clk;

  spot_corrector #(.PIX_W(PW), .IMG_W(TW), .IMG_H(TH)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .outValid(outValid), .outSof(outSof), .outEol(outEol), .outPix(outPix)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0, nBad = 0, outTotal = 0, frameBase = 0, lastEdge = 0;
  bit done = 1'b0;
  logic [PW-1:0] img [NPIX];
  int inEdge [NPIX];
  logic [PW-1:0] gotPix [NPIX];
  bit gotSof [NPIX], gotEol [NPIX];
  int gotEdge [NPIX];

  always @(negedge clk) begin
    if (outValid) begin
      if (outTotal - frameBase < NPIX && outTotal >= frameBase) begin
        gotPix[outTotal-frameBase]  = outPix;
        gotSof[outTotal-frameBase]  = outSof;
        gotEol[outTotal-frameBase]  = outEol;
        gotEdge[outTotal-frameBase] = cyc;
      end
      outTotal = outTotal + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  function automatic logic [PW-1:0] model(input int r, input int c);
    longint s = 0, avg, p, d;
    for (int dr = -2; dr <= 2; dr++)
      for (int dc = -2; dc <= 2; dc++) begin
        int rr, cc;
        if (dr == 0 && dc == 0) continue;
        rr = r + dr; cc = c + dc;
        if (rr < 0) rr = 0;
        if (rr > TH - 1) rr = TH - 1;
        if (cc < 0) cc = 0;
        if (cc > TW - 1) cc = TW - 1;
        s += longint'(img[rr*TW+cc]);
      end
    avg = (s + 12) / 24;
    p = longint'(img[r*TW+c]);
    d = (avg > p) ? avg - p : p - avg;
    return (d > (p >> 3)) ? PW'(avg) : PW'(p);
  endfunction

  task automatic runFrame(input bit gaps, input bit junk, input int focus, input logic [PW-1:0] focusExp);
    frameBase = outTotal;
    for (int i = 0; i < NPIX; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); inValid = 1'b0; inSof = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inPix = img[i];
      inEdge[i] = cyc + 1;
    end
    lastEdge = inEdge[NPIX-1];
    for (int j = 0; j < LAG; j++) begin
      @(negedge clk);
      inValid = junk; inSof = junk && (j == 3); inPix = PW'(24'hABC000 + j);
    end
    @(negedge clk); inValid = 1'b0; inSof = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 output count", outTotal - frameBase, NPIX);
    for (int k = 0; k < NPIX; k++) begin
      int r = k / TW, c = k % TW, expEdge;
      bit border = (r < 2) || (r >= TH - 2) || (c < 2) || (c >= TW - 2);
      expEdge = (k + LAG < NPIX) ? inEdge[k+LAG] + 3 : lastEdge + (k + LAG - NPIX + 1) + 3;
      if (border) chk("R3 border value", gotPix[k], model(r, c));
      else        chk("R1 R2 interior value", gotPix[k], model(r, c));
      chk("R4 sof flag", gotSof[k], (k == 0));
      chk("R4 eol flag", gotEol[k], (c == TW - 1));
      chk("R5 arrival edge", gotEdge[k], expEdge);
    end
    if (focus >= 0) chk("R2 table entry", gotPix[focus], focusExp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R5 watchdog expired actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] lfsr;
    // R7: reset state
    repeat (4) @(negedge clk);
    chk("R7 outValid in reset", outValid, 0);
    chk("R7 outSof in reset", outSof, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 outValid after reset", outValid, 0);
    chk("R7 outEol after reset", outEol, 0);

    // R6: beats without a frame start are dropped
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); inValid = 1'b1; inSof = 1'b0; inPix = PW'(i * 77);
    end
    @(negedge clk); inValid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 no output when idle", outTotal, 0);

    // R2: decision table, one suspect pixel inside a flat frame
    for (int t = 0; t < NVEC; t++) begin
      for (int i = 0; i < NPIX; i++) img[i] = VEC[t][47:24];
      img[FOCUS] = VEC[t][71:48];
      runFrame(1'b0, 1'b0, FOCUS, VEC[t][23:0]);
    end

    // R9: noisy frame fed with idle gaps
    lfsr = 24'h5A5A5A;
    for (int i = 0; i < NPIX; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      img[i] = 24'h400000 + {8'h00, lfsr[15:0]};
      if (i % 7 == 3) img[i] = (i % 2 == 1) ? 24'hF00000 : 24'h000100;
    end
    runFrame(1'b1, 1'b0, -1, '0);

    // R3, R8: gradient with spiked corners, junk during drain
    for (int i = 0; i < NPIX; i++) img[i] = PW'((i / TW) * 24'h010000 + (i % TW) * 24'h000100 + 24'h001000);
    img[0] = 24'hFFFFFF;
    img[NPIX-1] = 24'h000000;
    img[TW-1] = 24'h800000;
    runFrame(1'b0, 1'b1, -1, '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule